// File: doc/BRIEF.md
# Multi-Context Dual-Rail Lookup Cell

This block is a two-operand lookup cell that keeps one four-entry truth table per context, eight contexts by default. A context selector picks the plane that is active in a given cycle, so one cell can act as a different two-input gate from cycle to cycle without being reloaded. Tables are loaded through a write port that fills one plane per clock.

Each operand arrives as a level-encoded dual-rail pair: a value wire that carries the data bit and a parity wire. The phase of an operand is value XOR parity. A third wire per operand marks whether the pair carries data or a context bit. The handshake is modelled on a clock. The cell accepts a token only when both operands agree on phase and on the marker wire, and only when that phase differs from the phase already on the output. It then registers the looked-up bit as a new output pair with the same phase and raises a strobe for one cycle. In every other case the output pair holds its value.

Top module: `mctx_lut_cell`

## Requirements
- R1: While reset is low, and right after it is released, y_val, y_par and y_vld are 0 (output phase 0). Every truth-table plane reads as all zeros until it is written.
- R2: When cfg_we is 1 at a clock edge, cfg_tt is stored as the table of context cfg_ctx and the other planes are unchanged. An evaluation in that same cycle still uses the old table; the new table applies from the next cycle.
- R3: On an accepted token, y_val becomes bit index (2*a_val + b_val) of the table of context ctx_sel. y_par becomes y_val XOR p, where p is the common input phase. So the output phase equals p.
- R4: If the phase of operand a (a_val^a_par) differs from the phase of operand b, the output pair holds its value and y_vld stays 0.
- R5: If a_flag and b_flag differ, the inputs are blocked: the output pair holds its value and y_vld stays 0.
- R6: A token whose common phase equals the current output phase is ignored: the output holds its value and y_vld stays 0.
- R7: The result of a token sampled at clock edge k appears on y_val and y_par after edge k, together with y_vld = 1 for that one cycle. y_vld is 0 in every cycle whose output did not change at the edge before it.
- R8: All eight contexts are independent: each ctx_sel value addresses its own table, and the same operands give each plane's own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Truth-table write enable |
| cfg_ctx | input | 3 | Context whose table is written |
| cfg_tt | input | 4 | Table contents; bit i is the result for index i |
| ctx_sel | input | 3 | Context used for lookup |
| a_val | input | 1 | Operand a value wire (data bit) |
| a_par | input | 1 | Operand a parity wire |
| a_flag | input | 1 | Operand a data/context marker |
| b_val | input | 1 | Operand b value wire (data bit) |
| b_par | input | 1 | Operand b parity wire |
| b_flag | input | 1 | Operand b data/context marker |
| y_val | output | 1 | Output value wire |
| y_par | output | 1 | Output parity wire |
| y_vld | output | 1 | One-cycle strobe marking a new output token |

## Verification
The cell has a single register stage. Operands and the selected context sampled at one rising edge fix both the output pair and the strobe that are visible right after that edge. A table write at an edge is first seen by a token sampled at the following edge. The bench drives each cycle's inputs on the falling edge and pushes the expected pair and strobe for that cycle. A monitor pops one item shortly after every rising edge, so each comparison lands in exactly the cycle the result is due. Held outputs and missing strobes are checked in those same cycles.

// File: rtl/mctx_lut_pkg.sv
package mctx_lut_pkg;

   typedef struct packed {
      logic val;
      logic par;
   } dr_pair_t;

   function automatic logic dr_phase(input dr_pair_t p);
      return p.val ^ p.par;
   endfunction

   function automatic dr_pair_t dr_encode(input logic bit_v, input logic ph);
      dr_pair_t r;
      r.val = bit_v;
      r.par = bit_v ^ ph;
      return r;
   endfunction

endpackage

// File: rtl/mctx_tt_store.sv
module mctx_tt_store #(
   parameter int NUM_CTX = 8,
   parameter int TT_W    = 4,
   localparam int CTX_W  = $clog2(NUM_CTX),
   localparam int IDX_W  = $clog2(TT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTX_W-1:0] wr_ctx,
   input  logic [TT_W-1:0]  wr_bits,
   input  logic [CTX_W-1:0] rd_ctx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit
);

   logic [TT_W-1:0] plane_q [NUM_CTX];

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_plane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            plane_q[g] <= '0;
         else if (wr_en && (32'(wr_ctx) == g))
            plane_q[g] <= wr_bits;
      end
   end

   always_comb begin
      rd_bit = 1'b0;
      for (int c = 0; c < NUM_CTX; c++)
         if (32'(rd_ctx) == c)
            rd_bit = plane_q[c][rd_idx];
   end

endmodule

// File: rtl/mctx_dr_join.sv
module mctx_dr_join
   import mctx_lut_pkg::*;
(
   input  dr_pair_t   opa,
   input  dr_pair_t   opb,
   input  logic       flag_a,
   input  logic       flag_b,
   input  logic       out_phase,
   output logic       fire,
   output logic       tok_phase,
   output logic [1:0] tok_idx
);

   logic ph_a, ph_b, phase_match, flag_match, is_new;

   always_comb begin
      ph_a        = dr_phase(opa);
      ph_b        = dr_phase(opb);
      phase_match = (ph_a == ph_b);
      flag_match  = (flag_a == flag_b);
      is_new      = (ph_a != out_phase);
      fire        = phase_match && flag_match && is_new;
      tok_phase   = ph_a;
      tok_idx     = {opa.val, opb.val};
   end

endmodule

// File: rtl/mctx_dr_emit.sv
module mctx_dr_emit
   import mctx_lut_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fire,
   input  logic     tok_phase,
   input  logic     tok_bit,
   output dr_pair_t out_q,
   output logic     out_vld,
   output logic     out_phase
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= fire;
         if (fire)
            out_q <= dr_encode(tok_bit, tok_phase);
      end
   end

   assign out_phase = dr_phase(out_q);

   // R7: output changes only together with the strobe
   a_r7_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> $stable(out_q));

   // R6: every strobed token flips the output phase
   a_r6_new_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_phase != $past(out_phase)));

endmodule

// File: rtl/mctx_lut_cell.sv
module mctx_lut_cell
   import mctx_lut_pkg::*;
#(
   parameter int NUM_CTX = 8,
   parameter int LUT_IN  = 2,
   localparam int CTX_W  = $clog2(NUM_CTX),
   localparam int TT_W   = 1 << LUT_IN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CTX_W-1:0] cfg_ctx,
   input  logic [TT_W-1:0]  cfg_tt,
   input  logic [CTX_W-1:0] ctx_sel,
   input  logic             a_val,
   input  logic             a_par,
   input  logic             a_flag,
   input  logic             b_val,
   input  logic             b_par,
   input  logic             b_flag,
   output logic             y_val,
   output logic             y_par,
   output logic             y_vld
);

   if (LUT_IN != 2) begin : g_bad_in
      $error("mctx_lut_cell: only two operands are supported");
   end
   if (NUM_CTX < 2) begin : g_bad_ctx
      $error("mctx_lut_cell: at least two contexts required");
   end

   dr_pair_t   opa, opb, out_q;
   logic       fire, tok_phase, tok_bit, out_phase;
   logic [1:0] tok_idx;

   assign opa = '{val: a_val, par: a_par};
   assign opb = '{val: b_val, par: b_par};

   mctx_dr_join u_join (
      .opa       (opa),
      .opb       (opb),
      .flag_a    (a_flag),
      .flag_b    (b_flag),
      .out_phase (out_phase),
      .fire      (fire),
      .tok_phase (tok_phase),
      .tok_idx   (tok_idx)
   );

   mctx_tt_store #(.NUM_CTX(NUM_CTX), .TT_W(TT_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_ctx  (cfg_ctx),
      .wr_bits (cfg_tt),
      .rd_ctx  (ctx_sel),
      .rd_idx  (tok_idx),
      .rd_bit  (tok_bit)
   );

   mctx_dr_emit u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .tok_phase (tok_phase),
      .tok_bit   (tok_bit),
      .out_q     (out_q),
      .out_vld   (out_vld_w),
      .out_phase (out_phase)
   );

   logic out_vld_w;
   assign y_val = out_q.val;
   assign y_par = out_q.par;
   assign y_vld = out_vld_w;

   // R4: operands with differing phases leave the output untouched
   a_r4_hold_on_phase_split: assert property (@(posedge clk) disable iff (!rst_n)
      ((a_val ^ a_par) != (b_val ^ b_par)) |=> ($stable({y_val, y_par}) && !y_vld));

   // R5: disagreeing markers block the inputs
   a_r5_hold_on_flag_split: assert property (@(posedge clk) disable iff (!rst_n)
      (a_flag != b_flag) |=> ($stable({y_val, y_par}) && !y_vld));

   // R3: a strobed output carries the phase the operands had
   a_r3_phase_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      y_vld |-> ((y_val ^ y_par) == $past(a_val ^ a_par)));

endmodule

// File: tb/mctx_lut_cell_tb_top.sv
module mctx_lut_cell_tb_top;

   typedef struct {
      logic  vld;
      logic  val;
      logic  par;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_ctx = '0;
   logic [3:0] cfg_tt = '0;
   logic [2:0] ctx_sel = '0;
   logic       a_val = 1'b0, a_par = 1'b0, a_flag = 1'b0;
   logic       b_val = 1'b0, b_par = 1'b0, b_flag = 1'b0;
   logic       y_val, y_par, y_vld;

   int   n_checks = 0;
   int   n_errors = 0;
   exp_t sb_q[$];

   logic [3:0] m_tt [8];
   logic       m_ph = 1'b0;
   logic       m_val = 1'b0;
   logic       m_par = 1'b0;

   always #5 clk = ~clk;

   mctx_lut_cell dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_tt(cfg_tt),
      .ctx_sel(ctx_sel), .a_val(a_val), .a_par(a_par), .a_flag(a_flag),
      .b_val(b_val), .b_par(b_par), .b_flag(b_flag),
      .y_val(y_val), .y_par(y_par), .y_vld(y_vld)
   );

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: {vld,val,par} actual %b expected %b", tag, act, exp);
      end
   endtask

   // one driven cycle; ph_a/ph_b are the operand phases
   task automatic step(input string tag, input logic [2:0] ctx,
                       input logic da, input logic pa, input logic fa,
                       input logic db, input logic pb, input logic fb,
                       input logic we = 1'b0, input logic [2:0] wc = '0,
                       input logic [3:0] wt = '0);
      exp_t e;
      logic fire;
      @(negedge clk);
      ctx_sel = ctx;
      a_val = da; a_par = da ^ pa; a_flag = fa;
      b_val = db; b_par = db ^ pb; b_flag = fb;
      cfg_we = we; cfg_ctx = wc; cfg_tt = wt;
      fire = (fa == fb) && (pa == pb) && (pa != m_ph);
      if (fire) begin
         m_val = m_tt[ctx][{da, db}];
         m_par = m_val ^ pa;
         m_ph  = pa;
      end
      if (we) m_tt[wc] = wt;
      e.vld = fire; e.val = m_val; e.par = m_par; e.tag = tag;
      sb_q.push_back(e);
   endtask

   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(e.tag, {y_vld, y_val, y_par}, {e.vld, e.val, e.par});
      end
   end

   initial begin
      #2_000_000;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      logic ph;
      for (int i = 0; i < 8; i++) m_tt[i] = '0;
      repeat (3) @(negedge clk);
      check("R1 in reset", {y_vld, y_val, y_par}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {y_vld, y_val, y_par}, 3'b000);

      // R1: unwritten planes read zero (phase 1 token on all-ones operands)
      step("R1 zero plane", 3'd4, 1, 1, 0, 1, 1, 0);
      // R6: phase-0 tokens now repeat? output phase is 1, send phase 1 again
      step("R6 repeat ignored", 3'd4, 0, 1, 0, 1, 1, 0);

      // R2: load all planes with distinct patterns while tokens are ignored
      for (int c = 0; c < 8; c++)
         step("R2 load", 3'd0, 0, 1, 0, 0, 1, 0, 1'b1, 3'(c), 4'(c * 5 + 3));

      // R3, R8: sweep contexts and operand values with alternating phases
      ph = 1'b0;
      for (int c = 0; c < 8; c++)
         for (int k = 0; k < 4; k++) begin
            step("R3 R8 lookup", 3'(c), k[1], ph, 0, k[0], ph, 0);
            ph = ~ph;
         end

      // R7: back-to-back tokens each give a strobe, idle cycle gives none
      step("R7 token", 3'd1, 1, ph, 1, 0, ph, 1);
      step("R7 idle", 3'd1, 1, ph, 1, 0, ph, 1);
      ph = ~ph;

      // R4: phase split holds output
      step("R4 phase split", 3'd2, 1, ph, 0, 1, ~ph, 0);
      step("R4 phase split b", 3'd2, 0, ~ph, 0, 0, ph, 0);
      // R5: marker split blocks
      step("R5 flag split", 3'd2, 1, ph, 0, 1, ph, 1);
      step("R5 flag split b", 3'd2, 0, ph, 1, 1, ph, 0);
      step("R3 after blocks", 3'd2, 1, ph, 0, 1, ph, 0);
      ph = ~ph;

      // R2: write and evaluate same context in one cycle, then use new table
      step("R2 same-cycle old", 3'd6, 0, ph, 0, 1, ph, 0, 1'b1, 3'd6, 4'b1101);
      ph = ~ph;
      step("R2 next-cycle new", 3'd6, 0, ph, 0, 1, ph, 0);
      ph = ~ph;
      step("R2 other plane kept", 3'd5, 1, ph, 0, 0, ph, 0);

      @(posedge clk);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule